// File: doc/BRIEF.md
# DRBG Command Header Intake

This block is the command front end of a deterministic random bit generator. Software writes each command as a stream of 32-bit words through a single write port. The first word is a packed header carrying an operation code, a seed-word count, a multi-bit flag that disables live entropy, and a generate length counted in 128-bit blocks. The block decodes the header, takes the announced number of seed words, checks the command, and then either updates the internal generator state or runs a generate request.

The cryptographic core is replaced by a deterministic stand-in: a 32-bit state that is mixed with the XOR of the seed words, optionally with a live entropy word, and advanced by a fixed additive step for every output word. The command sequencing, the ready flag, the sticky error flag and the blocked output handshake are all complete. Generated words leave through a 32-bit read port, presented four at a time. A new group of four appears only after the previous group has been fully consumed.

Top module: `drbg_cmd_intake`

## Requirements
- R1: Header layout: bits 3:0 are the operation (1 instantiate, 2 reseed, 3 generate, 4 update, 5 uninstantiate), bits 7:4 the seed-word count N (0..15), bits 11:8 the entropy-disable flag, and bits 30:12 the generate length L in 128-bit blocks. Bit 31 is ignored. L is ignored by every operation except generate.
- R2: `cmd_rdy_o` is high when the block is idle, and a header is taken only on a write while it is high. It drops in the cycle after the header is taken and stays low until the command has completed, including the reading of all generated words. Writes while it is low, other than expected seed words, are ignored.
- R3: The N writes that follow a header are its seed words. Their XOR is the fold value F, and F is 0 when N = 0.
- R4: Instantiate sets the state to F ^ E and marks the generator instantiated. E is `entropy_i` sampled in the execute cycle, or 0 when the flag field equals 4'h6.
- R5: Reseed sets state ^= F ^ E, with E as in R4. Update sets state ^= F and never uses entropy. Neither operation needs prior instantiation.
- R6: Generate first sets state ^= F and then yields exactly 4·L words. For each word, state += 32'h9E3779B9 and the word is the new state. L = 0 completes with no output.
- R7: `gen_vld_o` is high while a four-word block is pending, and `gen_rdata_o` shows its current word. A cycle with `gen_rd_i` high while valid consumes that word. The next block is presented only after all four words have been read, and `gen_rdata_o` is 0 when not valid.
- R8: An operation code of 0 or 6..15, or a generate while not instantiated, sets `err_o`. The flag stays set until reset. The command's N seed words are still consumed, but the state is left unchanged and no output is produced.
- R9: Uninstantiate sets the state to 0 and clears the instantiated mark, so a later generate fails per R8.
- R10: After reset, `cmd_rdy_o` = 1, `gen_vld_o` = 0, `err_o` = 0 and `gen_rdata_o` = 0, and the generator is not instantiated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word (header or seed) |
| entropy_i | input | 32 | Live entropy word |
| cmd_rdy_o | output | 1 | Ready to accept a header |
| err_o | output | 1 | Sticky command error |
| gen_rd_i | input | 1 | Consume current output word |
| gen_vld_o | output | 1 | Output block pending |
| gen_rdata_o | output | 32 | Current output word |

## Verification
The write port and the read port can act in the same cycle. The bench drives a header write in the same cycle as the read of the final word of a generate, and also while the block is executing or waiting for a block to be read. The expected result is that each such write is dropped: the error flag stays clear, the generated words match the model, and the ready flag rises only in the cycle after the last read. A random command mix, compared against a bench model of the state, covers the ordinary interleaving of seed intake, entropy mixing and blocked output.

// File: rtl/drbg_intake_pkg.sv
package drbg_intake_pkg;

   localparam int unsigned HDR_W    = 32;
   localparam int unsigned OP_W     = 4;
   localparam int unsigned NSEED_W  = 4;
   localparam int unsigned FLAG_W   = 4;
   localparam int unsigned GLEN_W   = 19;
   localparam int unsigned OP_LSB   = 0;
   localparam int unsigned NSEED_LSB = 4;
   localparam int unsigned FLAG_LSB = 8;
   localparam int unsigned GLEN_LSB = 12;

   typedef enum logic [OP_W-1:0] {
      OP_NONE   = 4'd0,
      OP_INST   = 4'd1,
      OP_RESEED = 4'd2,
      OP_GEN    = 4'd3,
      OP_UPDATE = 4'd4,
      OP_UNINST = 4'd5
   } drbg_op_e;

   typedef struct packed {
      logic [OP_W-1:0]    op;
      logic               op_known;
      logic [NSEED_W-1:0] nseed;
      logic               ent_off;
      logic [GLEN_W-1:0]  glen;
   } drbg_hdr_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SEED = 2'd1,
      ST_EXEC = 2'd2,
      ST_GEN  = 2'd3
   } intake_st_e;

endpackage

// File: rtl/drbg_hdr_decode.sv
module drbg_hdr_decode
   import drbg_intake_pkg::*;
#(
   parameter logic [FLAG_W-1:0] FLAG_TRUE = 4'h6
) (
   input  logic [HDR_W-1:0] hdr_i,
   output drbg_hdr_t        hdr_o
);

   logic [OP_W-1:0] op_raw;
   logic            unused_msb;

   assign op_raw     = hdr_i[OP_LSB +: OP_W];
   assign unused_msb = hdr_i[HDR_W-1];

   always_comb begin
      hdr_o          = '0;
      hdr_o.op       = op_raw;
      hdr_o.nseed    = hdr_i[NSEED_LSB +: NSEED_W];
      hdr_o.ent_off  = (hdr_i[FLAG_LSB +: FLAG_W] == FLAG_TRUE);
      hdr_o.glen     = hdr_i[GLEN_LSB +: GLEN_W];
      hdr_o.op_known = (op_raw >= OP_INST) && (op_raw <= OP_UNINST);
   end

   // Immediate check: a decoded code marked known lies in the legal range (R1)
   always_comb begin
      if (hdr_o.op_known) begin
         p_known_range_r1: assert (hdr_o.op != 4'd0 && hdr_o.op < 4'd6)
            else $error("decoded op out of range");
      end
   end

endmodule

// File: rtl/drbg_stub_gen.sv
module drbg_stub_gen
   import drbg_intake_pkg::*;
#(
   parameter int unsigned    DW    = 32,
   parameter int unsigned    LANES = 4,
   parameter logic [DW-1:0]  STEP  = 32'h9E3779B9
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      exec_i,
   input  logic [OP_W-1:0]           op_i,
   input  logic [DW-1:0]             fold_i,
   input  logic [DW-1:0]             ent_i,
   input  logic                      ent_off_i,
   input  logic                      adv_i,
   output logic                      inst_o,
   output logic [LANES-1:0][DW-1:0]  blk_o
);

   localparam logic [DW-1:0] ADV = DW'(STEP * LANES);

   logic [DW-1:0] state_q;
   logic [DW-1:0] ent_eff;
   logic          inst_q;

   assign ent_eff = ent_off_i ? '0 : ent_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= '0;
         inst_q  <= 1'b0;
      end else if (exec_i) begin
         unique case (op_i)
            OP_INST: begin
               state_q <= fold_i ^ ent_eff;
               inst_q  <= 1'b1;
            end
            OP_RESEED: state_q <= state_q ^ fold_i ^ ent_eff;
            OP_GEN:    state_q <= state_q ^ fold_i;
            OP_UPDATE: state_q <= state_q ^ fold_i;
            OP_UNINST: begin
               state_q <= '0;
               inst_q  <= 1'b0;
            end
            default: ;
         endcase
      end else if (adv_i) begin
         state_q <= state_q + ADV;
      end
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      localparam logic [DW-1:0] OFS = DW'(STEP * (j + 1));
      assign blk_o[j] = state_q + OFS;
   end

   assign inst_o = inst_q;

   // Execution and block advance never coincide (R6)
   p_exec_adv_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(exec_i && adv_i));

   // Advancing only happens while instantiated (R9)
   p_adv_needs_inst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      adv_i |-> inst_q);

endmodule

// File: rtl/drbg_blk_out.sv
module drbg_blk_out #(
   parameter int unsigned DW    = 32,
   parameter int unsigned LANES = 4
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      load_i,
   input  logic [LANES-1:0][DW-1:0]  blk_i,
   input  logic                      rd_i,
   output logic                      vld_o,
   output logic [DW-1:0]             rdata_o,
   output logic                      drained_o
);

   localparam int unsigned IW = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [IW-1:0] LAST = IW'(LANES - 1);

   logic [LANES-1:0][DW-1:0] buf_q;
   logic [IW-1:0]            idx_q;
   logic                     vld_q;
   logic                     take;

   assign take      = vld_q && rd_i;
   assign drained_o = take && (idx_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q <= 1'b0;
         idx_q <= '0;
      end else if (load_i) begin
         vld_q <= 1'b1;
         idx_q <= '0;
      end else if (take) begin
         idx_q <= idx_q + 1'b1;
         if (idx_q == LAST) vld_q <= 1'b0;
      end
   end

   for (genvar j = 0; j < LANES; j++) begin : g_buf
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     buf_q[j] <= '0;
         else if (load_i) buf_q[j] <= blk_i[j];
      end
   end

   assign vld_o   = vld_q;
   assign rdata_o = vld_q ? buf_q[idx_q] : '0;

   // A new block is never loaded over a pending one (R7)
   p_no_overwrite_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |-> !vld_q);

   // Without a read, a pending word holds (R7)
   p_hold_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_q && !rd_i && !load_i) |=> (vld_q && $stable(rdata_o)));

endmodule

// File: rtl/drbg_cmd_intake.sv
module drbg_cmd_intake
   import drbg_intake_pkg::*;
#(
   parameter int unsigned       DW        = 32,
   parameter int unsigned       LANES     = 4,
   parameter logic [FLAG_W-1:0] FLAG_TRUE = 4'h6,
   parameter logic [DW-1:0]     STEP      = 32'h9E3779B9
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          cmd_wr_i,
   input  logic [DW-1:0] cmd_wdata_i,
   input  logic [DW-1:0] entropy_i,
   output logic          cmd_rdy_o,
   output logic          err_o,
   input  logic          gen_rd_i,
   output logic          gen_vld_o,
   output logic [DW-1:0] gen_rdata_o
);

   initial begin
      if (DW != HDR_W) $error("DW must equal the header width");
      if (LANES < 1)   $error("LANES must be at least 1");
   end

   drbg_hdr_t                hdr_dec, hdr_q;
   intake_st_e               st_q;
   logic [NSEED_W-1:0]       seed_left_q;
   logic [DW-1:0]            fold_q;
   logic [GLEN_W-1:0]        blk_left_q;
   logic                     err_q;
   logic                     inst;
   logic                     bad_cmd;
   logic                     exec_ok;
   logic                     load_blk;
   logic                     drained;
   logic [LANES-1:0][DW-1:0] blk;

   drbg_hdr_decode #(.FLAG_TRUE(FLAG_TRUE)) u_dec (
      .hdr_i (cmd_wdata_i),
      .hdr_o (hdr_dec)
   );

   assign bad_cmd  = !hdr_q.op_known || ((hdr_q.op == OP_GEN) && !inst);
   assign exec_ok  = (st_q == ST_EXEC) && !bad_cmd;
   assign load_blk = (st_q == ST_GEN) && !gen_vld_o && (blk_left_q != '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q        <= ST_IDLE;
         hdr_q       <= '0;
         seed_left_q <= '0;
         fold_q      <= '0;
         blk_left_q  <= '0;
         err_q       <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (cmd_wr_i) begin
               hdr_q       <= hdr_dec;
               fold_q      <= '0;
               seed_left_q <= hdr_dec.nseed;
               st_q        <= (hdr_dec.nseed != '0) ? ST_SEED : ST_EXEC;
            end
            ST_SEED: if (cmd_wr_i) begin
               fold_q      <= fold_q ^ cmd_wdata_i;
               seed_left_q <= seed_left_q - 1'b1;
               if (seed_left_q == NSEED_W'(1)) st_q <= ST_EXEC;
            end
            ST_EXEC: begin
               if (bad_cmd) begin
                  err_q <= 1'b1;
                  st_q  <= ST_IDLE;
               end else if ((hdr_q.op == OP_GEN) && (hdr_q.glen != '0)) begin
                  blk_left_q <= hdr_q.glen;
                  st_q       <= ST_GEN;
               end else begin
                  st_q <= ST_IDLE;
               end
            end
            ST_GEN: begin
               if (load_blk) blk_left_q <= blk_left_q - 1'b1;
               if (drained && (blk_left_q == '0)) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   drbg_stub_gen #(.DW(DW), .LANES(LANES), .STEP(STEP)) u_gen (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .exec_i    (exec_ok),
      .op_i      (hdr_q.op),
      .fold_i    (fold_q),
      .ent_i     (entropy_i),
      .ent_off_i (hdr_q.ent_off),
      .adv_i     (load_blk),
      .inst_o    (inst),
      .blk_o     (blk)
   );

   drbg_blk_out #(.DW(DW), .LANES(LANES)) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load_blk),
      .blk_i     (blk),
      .rd_i      (gen_rd_i),
      .vld_o     (gen_vld_o),
      .rdata_o   (gen_rdata_o),
      .drained_o (drained)
   );

   assign cmd_rdy_o = (st_q == ST_IDLE);
   assign err_o     = err_q;

   // Idle never coexists with a pending output block (R2)
   p_rdy_no_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_rdy_o |-> !gen_vld_o);

   // Error flag is sticky (R8)
   p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);

   // Seed collection always has words outstanding (R3)
   p_seed_left_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_SEED) |-> (seed_left_q != '0));

   // A taken header drops ready on the next cycle (R2)
   p_rdy_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_rdy_o && cmd_wr_i) |=> !cmd_rdy_o);

   // Output only flows while generating (R6)
   p_vld_in_gen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gen_vld_o |-> (st_q == ST_GEN));

endmodule

// File: tb/drbg_cmd_intake_tb.sv
module drbg_cmd_intake_tb;

   localparam logic [31:0] STEP = 32'h9E3779B9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic [31:0] entropy = '0;
   logic        cmd_rdy, err, gen_rd = 1'b0, gen_vld;
   logic [31:0] gen_rdata;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_s = '0;
   logic        m_inst = 1'b0;
   logic        m_err = 1'b0;
   logic [31:0] sd [16];

   always #2.5 clk = ~clk;

   drbg_cmd_intake u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .cmd_wr_i    (cmd_wr),
      .cmd_wdata_i (cmd_wdata),
      .entropy_i   (entropy),
      .cmd_rdy_o   (cmd_rdy),
      .err_o       (err),
      .gen_rd_i    (gen_rd),
      .gen_vld_o   (gen_vld),
      .gen_rdata_o (gen_rdata)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_hdr(input logic [3:0] op, input logic [3:0] flag,
                                          input int n, input logic [18:0] glen,
                                          input logic b31);
      return {b31, glen, flag, 4'(n), op};
   endfunction

   function automatic logic [31:0] fold_of(input int n);
      logic [31:0] f = '0;
      for (int i = 0; i < n; i++) f ^= sd[i];
      return f;
   endfunction

   // Bench model of R4, R5, R6 (fold), R8, R9
   task automatic model_apply(input logic [3:0] op, input logic [3:0] flag,
                              input int n, input logic [31:0] ent);
      logic [31:0] f = fold_of(n);
      logic [31:0] e = (flag == 4'h6) ? 32'h0 : ent;
      if (op == 4'd0 || op > 4'd5 || (op == 4'd3 && !m_inst)) m_err = 1'b1;
      else case (op)
         4'd1: begin m_s = f ^ e; m_inst = 1'b1; end
         4'd2: m_s = m_s ^ f ^ e;
         4'd3: m_s = m_s ^ f;
         4'd4: m_s = m_s ^ f;
         default: begin m_s = '0; m_inst = 1'b0; end
      endcase
   endtask

   task automatic wait_rdy(input string req);
      int t = 0;
      while (!cmd_rdy && t < 2000) begin @(negedge clk); t++; end
      chk(cmd_rdy, req, {31'd0, cmd_rdy}, 32'd1);
   endtask

   task automatic send(input logic [3:0] op, input logic [3:0] flag, input int n,
                       input logic [18:0] glen, input logic b31, input logic [31:0] ent);
      wait_rdy("R2 ready before header");
      entropy   = ent;
      cmd_wr    = 1'b1;
      cmd_wdata = mk_hdr(op, flag, n, glen, b31);
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         cmd_wdata = sd[i];
         @(negedge clk);
      end
      cmd_wr = 1'b0;
      model_apply(op, flag, n, ent);
   endtask

   task automatic read_blocks(input int nblk, input string req, input logic poke_last);
      for (int b = 0; b < nblk; b++) begin
         int t = 0;
         while (!gen_vld && t < 2000) begin @(negedge clk); t++; end
         chk(gen_vld, "R7 block valid", {31'd0, gen_vld}, 32'd1);
         gen_rd = 1'b1;
         for (int w = 0; w < 4; w++) begin
            m_s = m_s + STEP;
            chk(gen_vld && gen_rdata == m_s, req, gen_rdata, m_s);
            if (poke_last && b == nblk - 1 && w == 3) begin
               cmd_wr    = 1'b1;
               cmd_wdata = 32'h0000_000F;
            end
            @(negedge clk);
         end
         gen_rd = 1'b0;
         cmd_wr = 1'b0;
         // R7: next block only after a gap, never back to back with the read
         chk(!gen_vld, "R7 gating after drain", {31'd0, gen_vld}, 32'd0);
      end
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 16; i++) sd[i] = '0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(cmd_rdy == 1'b1, "R10 rdy", {31'd0, cmd_rdy}, 32'd1);
      chk(gen_vld == 1'b0, "R10 vld", {31'd0, gen_vld}, 32'd0);
      chk(err == 1'b0, "R10 err", {31'd0, err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(gen_rdata == 32'd0, "R10 rdata", gen_rdata, 32'd0);

      // R4 instantiate with seeds and entropy; R3 fold; R6 generate
      sd[0] = 32'h1234_5678; sd[1] = 32'h0F0F_00FF;
      send(4'd1, 4'h9, 2, 19'd0, 1'b0, 32'hA5A5_0001);
      send(4'd3, 4'h0, 0, 19'd1, 1'b0, 32'h0);
      chk(!cmd_rdy, "R2 ready low during generate", {31'd0, cmd_rdy}, 32'd0);
      read_blocks(1, "R6 word after seeded instantiate", 1'b0);
      wait_rdy("R2 ready after generate");

      // R4 entropy disabled by flag 4'h6
      sd[0] = 32'hDEAD_BEEF;
      send(4'd1, 4'h6, 1, 19'd0, 1'b0, 32'hFFFF_0000);
      send(4'd3, 4'h0, 0, 19'd1, 1'b0, 32'h0);
      read_blocks(1, "R4 flag disables entropy", 1'b0);

      // R1 bit 31 ignored, L=2 upper field, generate with seeds (R6)
      sd[0] = 32'h0000_0003; sd[1] = 32'h1111_1111; sd[2] = 32'h8000_0000;
      send(4'd3, 4'h3, 3, 19'd2, 1'b1, 32'h0);
      read_blocks(2, "R1 header fields with msb set", 1'b0);

      // R5 reseed and update; update ignores entropy and L
      sd[0] = 32'h0BAD_F00D;
      send(4'd2, 4'h0, 1, 19'd5, 1'b0, 32'h1357_9BDF);
      send(4'd4, 4'h0, 1, 19'd7, 1'b0, 32'hFFFF_FFFF);
      wait_rdy("R5 non-generate with length completes");
      chk(!gen_vld, "R1 length ignored outside generate", {31'd0, gen_vld}, 32'd0);
      send(4'd3, 4'h0, 0, 19'd1, 1'b0, 32'h0);
      read_blocks(1, "R5 reseed then update", 1'b0);

      // R6 zero-length generate
      send(4'd3, 4'h0, 0, 19'd0, 1'b0, 32'h0);
      repeat (4) @(negedge clk);
      chk(cmd_rdy && !gen_vld, "R6 zero length", {30'd0, cmd_rdy, gen_vld}, 32'd2);

      // R2 writes while busy are ignored, and a header on the final read cycle
      send(4'd3, 4'h0, 0, 19'd2, 1'b0, 32'h0);
      cmd_wr = 1'b1; cmd_wdata = 32'h0000_000E;
      repeat (2) @(negedge clk);
      cmd_wr = 1'b0;
      read_blocks(2, "R2 busy writes ignored", 1'b1);
      chk(cmd_rdy, "R2 ready after last read", {31'd0, cmd_rdy}, 32'd1);
      chk(!err, "R2 same-cycle header dropped", {31'd0, err}, 32'd0);

      // Random mix without error cases
      for (int it = 0; it < 40; it++) begin
         logic [3:0] op = 4'($urandom_range(1, 5));
         int n = $urandom_range(0, 4);
         logic [3:0] fl = ($urandom_range(0, 1) == 1) ? 4'h6 : 4'($urandom_range(0, 15));
         logic [31:0] ent = $urandom;
         if (op == 4'd3 && !m_inst) op = 4'd1;
         for (int i = 0; i < n; i++) sd[i] = $urandom;
         if (op == 4'd3) begin
            int l = $urandom_range(1, 3);
            send(op, fl, n, 19'(l), 1'($urandom_range(0, 1)), ent);
            read_blocks(l, "R6 random generate", 1'b0);
         end else begin
            send(op, fl, n, 19'($urandom_range(0, 3)), 1'b0, ent);
         end
      end
      wait_rdy("R2 ready after random");
      chk(!err, "R8 no error on legal mix", {31'd0, err}, 32'd0);
      if (!m_inst) send(4'd1, 4'h0, 0, 19'd0, 1'b0, 32'h2468_ACE0);

      // R8 unknown code with seeds: error, state unchanged, seeds consumed
      sd[0] = 32'hFFFF_FFFF; sd[1] = 32'h7777_7777;
      send(4'd7, 4'h0, 2, 19'd1, 1'b0, 32'h0);
      wait_rdy("R8 bad code completes");
      chk(err, "R8 unknown code sets error", {31'd0, err}, 32'd1);
      chk(!gen_vld, "R8 no output on bad code", {31'd0, gen_vld}, 32'd0);
      send(4'd3, 4'h0, 0, 19'd1, 1'b0, 32'h0);
      read_blocks(1, "R8 state unchanged after drop", 1'b0);

      // R9 uninstantiate then generate fails
      send(4'd5, 4'h0, 0, 19'd0, 1'b0, 32'h0);
      sd[0] = 32'h0101_0101;
      send(4'd3, 4'h0, 1, 19'd1, 1'b0, 32'h0);
      repeat (4) @(negedge clk);
      chk(!gen_vld && cmd_rdy, "R9 generate after uninstantiate dropped",
          {30'd0, gen_vld, cmd_rdy}, 32'd1);
      chk(err, "R8 sticky error", {31'd0, err}, 32'd1);
      send(4'd1, 4'h0, 0, 19'd0, 1'b0, 32'h0F1E_2D3C);
      send(4'd3, 4'h0, 0, 19'd1, 1'b0, 32'h0);
      read_blocks(1, "R9 reinstantiate after uninstantiate", 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule